// File: doc/BRIEF.md
# Byte-Wide Flash Command Front End

This block is the command-handling front of a single byte-wide flash device. A host drives it with the usual active-low chip select, output enable and write enable, an address bus and a byte of write data. A separate input reports whether the high programming voltage is present. All of these are sampled in the block's clock domain. The host writes command bytes that move a mode register between reading, programming, erasing and the two verify states. The block turns those modes into writes on a small behavioural byte array that is held in a block-RAM style memory.

Each write-enable cycle is seen as two events. On the falling strobe the block captures the bus address. On the rising strobe it captures the data or command byte. After a program-arm command, the next write cycle is taken as a data cycle and stores its byte at the address captured on its falling strobe. A double erase command starts a sweep that fills the array with ones, one location per clock, from location 0 upward. An erase-verify command stops that sweep. In both verify modes, reads ignore the address bus and return the location the block has latched. Without the programming voltage, the mode register is held at the read state and writes have no effect.

Top module: `flash_cmd_front`

## Requirements
- R1: When chip select is low, a falling write strobe captures the address bus. `lat_addr` shows the captured value one clock after the edge is sampled.
- R2: When chip select is low, a rising write strobe captures `din`. `lat_data` shows the captured value one clock after the edge is sampled.
- R3: While `vpp_hi` is low, `mode` is forced to read (code 0) on the next clock and no write strobe changes the array.
- R4: When `vpp_hi` rises, `mode` reads 0 and keeps that value until a command byte is written.
- R5: Command 8'h40 moves `mode` to program-arm (code 1). The next write cycle stores its `din` at the address from its own falling strobe and moves `mode` to program-wait (code 2). This holds even if that byte matches a command code.
- R6: Command 8'hC0 moves `mode` to program-verify (code 3). Reads in this mode return the location that was last programmed, whatever the address bus carries.
- R7: Command 8'h20 moves `mode` to erase-arm (code 4). A second 8'h20 written directly after it moves `mode` to erase-run (code 5). Erase-run raises `erase_busy` and writes 8'hFF to every location, index 0 first, one per clock, over 2^AW clocks. Any other byte written after the first 8'h20 cancels the erase and leaves the array unchanged.
- R8: Command 8'hA0 moves `mode` to erase-verify (code 6) and stops any sweep in progress. Reads in this mode return the location whose address was captured on the falling strobe of the 8'hA0 cycle.
- R9: Command cycles never change array contents. Only the program data cycle and the erase sweep write the array.
- R10: `dout_oe` is the registered value of (chip select low and output enable low). It is therefore low one clock after chip select goes high, whatever output enable is doing.
- R11: Any byte other than 8'h00, 8'h20, 8'h40, 8'hA0 or 8'hC0, written outside a program data cycle, returns `mode` to read (code 0). Writing 8'h00 also selects read.
- R12: Write strobes seen while chip select is high change neither the latches nor the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| vpp_hi | input | 1 | High programming voltage present |
| addr | input | AW | Byte address |
| din | input | 8 | Write data or command byte |
| dout | output | 8 | Registered read data |
| dout_oe | output | 1 | Enable for the external data driver; low means high impedance |
| mode | output | 3 | Current mode code |
| lat_addr | output | AW | Address captured on the last selected falling strobe |
| lat_data | output | 8 | Byte captured on the last selected rising strobe |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
The assertions treat every control input as synchronous to `clk` and stable for at least one clock between changes. A strobe edge is therefore exactly one change of `we_n` between two clock samples. The bench drives all inputs on the falling clock edge and holds each strobe level for a full cycle. It also keeps chip select low across both strobe edges of a selected write. It never changes `vpp_hi` within a write cycle, so every write is either entirely with the programming voltage or entirely without it.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    MD_READ      = 3'd0,
    MD_PGM_ARM   = 3'd1,
    MD_PGM_WAIT  = 3'd2,
    MD_PGM_CHECK = 3'd3,
    MD_ERS_ARM   = 3'd4,
    MD_ERS_RUN   = 3'd5,
    MD_ERS_CHECK = 3'd6
  } mode_e;

  localparam logic [DW-1:0] OP_READ     = 8'h00;
  localparam logic [DW-1:0] OP_PGM      = 8'h40;
  localparam logic [DW-1:0] OP_PGM_CHK  = 8'hC0;
  localparam logic [DW-1:0] OP_ERS      = 8'h20;
  localparam logic [DW-1:0] OP_ERS_CHK  = 8'hA0;
endpackage

// File: rtl/flash_strobe_edge.sv
module flash_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic strb_n,
  output logic fall,
  output logic rise
);
  logic strb_q;

  always_ff @(posedge clk) begin
    if (rst) strb_q <= 1'b1;
    else     strb_q <= strb_n;
  end

  assign fall = !sel_n &&  strb_q && !strb_n;
  assign rise = !sel_n && !strb_q &&  strb_n;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vpp_hi,
  input  logic          fall,
  input  logic          rise,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output mode_e         mode,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_data,
  output logic [AW-1:0] chk_addr,
  output logic          pgm_we
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MD_READ;
      lat_addr <= '0;
      lat_data <= '0;
      chk_addr <= '0;
      pgm_we   <= 1'b0;
    end else begin
      pgm_we <= 1'b0;
      if (fall) lat_addr <= addr;
      if (rise) lat_data <= din;
      if (!vpp_hi) begin
        mode <= MD_READ;
      end else if (rise) begin
        if (mode == MD_PGM_ARM) begin
          pgm_we   <= 1'b1;
          chk_addr <= lat_addr;
          mode     <= MD_PGM_WAIT;
        end else begin
          case (din)
            OP_READ:    mode <= MD_READ;
            OP_PGM:     mode <= MD_PGM_ARM;
            OP_PGM_CHK: mode <= MD_PGM_CHECK;
            OP_ERS:     mode <= (mode == MD_ERS_ARM) ? MD_ERS_RUN : MD_ERS_ARM;
            OP_ERS_CHK: begin
              mode     <= MD_ERS_CHECK;
              chk_addr <= lat_addr;
            end
            default:    mode <= MD_READ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/flash_erase_sweep.sv
module flash_erase_sweep #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] idx;
  logic          done;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      idx  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      idx <= idx + 1'b1;
      if (idx == LAST) done <= 1'b1;
    end
  end

  assign busy    = run && !done;
  assign wr_en   = busy;
  assign wr_addr = idx;
endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flash_cmd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          vpp_hi,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_oe,
  output logic [2:0]    mode,
  output logic [AW-1:0] lat_addr,
  output logic [7:0]    lat_data,
  output logic          erase_busy
);
  localparam logic [DW-1:0] ERASED = {DW{1'b1}};

  logic          fall, rise, pgm_we, swp_we;
  logic [AW-1:0] chk_addr, swp_addr, raddr, waddr;
  logic [DW-1:0] wdata;
  mode_e         md;

  flash_strobe_edge u_edge (
    .clk(clk), .rst(rst), .sel_n(ce_n), .strb_n(we_n),
    .fall(fall), .rise(rise)
  );

  flash_cmd_decoder #(.AW(AW)) u_dec (
    .clk(clk), .rst(rst), .vpp_hi(vpp_hi), .fall(fall), .rise(rise),
    .addr(addr), .din(din), .mode(md), .lat_addr(lat_addr),
    .lat_data(lat_data), .chk_addr(chk_addr), .pgm_we(pgm_we)
  );

  flash_erase_sweep #(.AW(AW)) u_swp (
    .clk(clk), .rst(rst), .run(md == MD_ERS_RUN && vpp_hi),
    .wr_en(swp_we), .wr_addr(swp_addr), .busy(erase_busy)
  );

  always_comb begin
    if (swp_we) begin
      waddr = swp_addr;
      wdata = ERASED;
    end else begin
      waddr = chk_addr;
      wdata = lat_data;
    end
    if (md == MD_PGM_CHECK || md == MD_ERS_CHECK) raddr = chk_addr;
    else                                          raddr = addr;
  end

  flash_byte_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(swp_we || pgm_we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) dout_oe <= 1'b0;
    else     dout_oe <= !ce_n && !oe_n;
  end

  assign mode = md;
endmodule

// File: rtl/flash_cmd_front_chk.sv
module flash_cmd_front_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          we_n,
  input logic          vpp_hi,
  input logic [AW-1:0] addr,
  input logic [7:0]    din,
  input logic [2:0]    mode,
  input logic [AW-1:0] lat_addr,
  input logic [7:0]    lat_data,
  input logic          dout_oe,
  input logic          erase_busy
);
  logic we_prev;
  always_ff @(posedge clk) begin
    if (rst) we_prev <= 1'b1;
    else     we_prev <= we_n;
  end

  wire c_fall = !ce_n && we_prev && !we_n;
  wire c_rise = !ce_n && !we_prev && we_n;
  wire c_known = din == 8'h00 || din == 8'h20 || din == 8'h40 ||
                 din == 8'hA0 || din == 8'hC0;

  a_r1_addr_on_fall: assert property (@(posedge clk) disable iff (rst)
    c_fall |=> lat_addr == $past(addr));

  a_r2_data_on_rise: assert property (@(posedge clk) disable iff (rst)
    c_rise |=> lat_data == $past(din));

  a_r3_no_vpp_read: assert property (@(posedge clk) disable iff (rst)
    !vpp_hi |=> mode == 3'd0);

  a_r7_busy_in_run: assert property (@(posedge clk) disable iff (rst)
    erase_busy |-> mode == 3'd5);

  a_r10_deselect_hiz: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !dout_oe);

  a_r11_unknown_read: assert property (@(posedge clk) disable iff (rst)
    (vpp_hi && c_rise && mode != 3'd1 && !c_known) |=> mode == 3'd0);

  a_r12_deselect_hold: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> $stable(lat_addr) && $stable(lat_data));
endmodule

bind flash_cmd_front flash_cmd_front_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .vpp_hi(vpp_hi),
  .addr(addr), .din(din), .mode(mode), .lat_addr(lat_addr),
  .lat_data(lat_data), .dout_oe(dout_oe), .erase_busy(erase_busy)
);

// File: tb/tb_flash_cmd_front.sv
module tb_flash_cmd_front;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vpp_hi = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_oe, erase_busy;
  logic [2:0] mode;
  logic [AW-1:0] lat_addr;
  logic [7:0] lat_data;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_front #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .vpp_hi(vpp_hi), .addr(addr), .din(din), .dout(dout),
    .dout_oe(dout_oe), .mode(mode), .lat_addr(lat_addr),
    .lat_data(lat_data), .erase_busy(erase_busy)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input bit sel, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = ~sel; addr = a; we_n = 1'b0;
    @(negedge clk); din = d; we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk); d = dout;
    chk("R10 oe during read", int'(dout_oe), 1);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 reset mode", int'(mode), 0);
    chk("R10 reset oe", int'(dout_oe), 0);
    chk("R7 reset busy", int'(erase_busy), 0);
    chk("R1 reset lat_addr", int'(lat_addr), 0);

    vpp_hi = 1'b1;
    @(negedge clk);
    chk("R4 vpp rise mode", int'(mode), 0);

    bus_write(1'b1, 4'd0, 8'h20);
    chk("R7 erase arm", int'(mode), 4);
    bus_write(1'b1, 4'd0, 8'h20);
    chk("R7 erase run", int'(mode), 5);
    chk("R7 busy raised", int'(erase_busy), 1);
    repeat (DEPTH + 2) @(negedge clk);
    chk("R7 busy cleared", int'(erase_busy), 0);
    bus_write(1'b1, 4'd0, 8'hA0);
    chk("R8 erase verify mode", int'(mode), 6);
    bus_write(1'b1, 4'd0, 8'h00);
    chk("R11 read cmd", int'(mode), 0);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(AW'(i), rd);
      chk("R7 erased", int'(rd), 8'hFF);
    end

    for (int i = 0; i < DEPTH; i++) begin
      bus_write(1'b1, AW'(i + 7), 8'h40);
      chk("R5 program arm", int'(mode), 1);
      bus_write(1'b1, AW'(i), pat(i));
      chk("R5 program wait", int'(mode), 2);
      chk("R1 latched addr", int'(lat_addr), i);
      chk("R2 latched data", int'(lat_data), int'(pat(i)));
      bus_write(1'b1, AW'(i ^ 5), 8'hC0);
      chk("R6 verify mode", int'(mode), 3);
      bus_read(AW'(i ^ 3), rd);
      chk("R6 verify read", int'(rd), int'(pat(i)));
    end
    bus_write(1'b1, 4'd0, 8'h00);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(AW'(i), rd);
      chk("R5 programmed", int'(rd), int'(pat(i)));
    end

    // Program data byte equal to a command code
    bus_write(1'b1, 4'd0, 8'h40);
    bus_write(1'b1, 4'd10, 8'h20);
    chk("R5 data not command", int'(mode), 2);
    bus_write(1'b1, 4'd0, 8'h00);
    bus_read(4'd10, rd);
    chk("R5 command-valued data", int'(rd), 8'h20);

    bus_write(1'b1, 4'd7, 8'h00);
    bus_write(1'b1, 4'd9, 8'hC0);
    bus_write(1'b1, 4'd9, 8'h00);
    bus_read(4'd7, rd);
    chk("R9 cmd no write", int'(rd), int'(pat(7)));
    bus_read(4'd9, rd);
    chk("R9 cmd no write", int'(rd), int'(pat(9)));

    for (int k = 0; k < 4; k++) begin
      logic [7:0] junk;
      junk = (k == 0) ? 8'h01 : (k == 1) ? 8'h41 : (k == 2) ? 8'hFF : 8'h21;
      bus_write(1'b1, 4'd0, 8'h20);
      bus_write(1'b1, 4'd4, junk);
      chk("R11 unknown to read", int'(mode), 0);
    end
    bus_read(4'd0, rd);
    chk("R7 cancelled erase", int'(rd), int'(pat(0)));
    bus_read(4'd4, rd);
    chk("R9 unknown no write", int'(rd), int'(pat(4)));

    bus_write(1'b0, 4'd11, 8'h40);
    chk("R12 deselected mode", int'(mode), 0);
    chk("R12 deselected addr", int'(lat_addr), 4);
    chk("R12 deselected data", int'(lat_data), 8'h21);

    vpp_hi = 1'b0;
    bus_write(1'b1, 4'd0, 8'h40);
    chk("R3 no vpp mode", int'(mode), 0);
    bus_write(1'b1, 4'd3, 8'h5A);
    chk("R3 no vpp mode", int'(mode), 0);
    vpp_hi = 1'b1;
    @(negedge clk);
    chk("R4 vpp back mode", int'(mode), 0);
    bus_read(4'd3, rd);
    chk("R3 array kept", int'(rd), int'(pat(3)));

    bus_write(1'b1, 4'd0, 8'h40);
    vpp_hi = 1'b0;
    @(negedge clk);
    vpp_hi = 1'b1;
    @(negedge clk);
    chk("R3 vpp drop resets", int'(mode), 0);

    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    chk("R10 deselect hiz", int'(dout_oe), 0);
    ce_n = 1'b0;
    @(negedge clk);
    chk("R10 select drive", int'(dout_oe), 1);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    chk("R10 release", int'(dout_oe), 0);

    bus_write(1'b1, 4'd0, 8'h20);
    bus_write(1'b1, 4'd0, 8'h20);
    bus_write(1'b1, 4'd0, 8'hA0);
    chk("R8 stop mode", int'(mode), 6);
    chk("R8 sweep stopped", int'(erase_busy), 0);
    bus_read(4'd9, rd);
    chk("R8 verify latched addr", int'(rd), 8'hFF);
    bus_write(1'b1, 4'd0, 8'h00);
    bus_read(AW'(DEPTH - 1), rd);
    chk("R8 partial erase", int'(rd), int'(pat(DEPTH - 1)));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule